// File: doc/BRIEF.md
# Frame-Delayed Serial Channel Bypass Router

This block is the bypass path of a time-division serial voice port. Two channel strobes mark two eight-bit timeslots in every 8 kHz frame. The first strobe window is followed by the second, and the end of the second window closes the frame. During these windows the block captures the serial bits on two PCM input lines and one ADPCM input line. It holds the captured bytes for exactly two frames and then drives them out again, on the output line and timeslot that the routing configuration picks. The block performs no companding and no ADPCM arithmetic.

Two static controls set the routing. A mode input selects one of two bypasses. In octet bypass, whole 8-bit PCM channel bytes are carried. In codeword bypass, 2-bit codewords are carried: four of them are packed into one ADPCM timeslot. A select input chooses which channel pair or which timeslot is used. Per-direction enable inputs can put the PCM outputs or the ADPCM output into high impedance, while capture carries on. Each output is high impedance whenever it is not actively driving a timeslot.

The system clock `clk` oversamples the serial bit clock `bclk`. Inputs are taken at the falling edges of `bclk`, and outputs advance at its rising edges.

Top module: `frame_delay_bypass`

## Requirements
- R1: After reset, every output is high impedance while both strobes are low. During the first two frames after reset, every output that is enabled and active drives zeros.
- R2: A byte driven in frame N always comes from the input captured in frame N-2. Frames are counted from the first frame after reset.
- R3: Octet mode, select=0. The ADPCM output drives the byte that PCM input 1 carried in the same slot. PCM output 1 drives the byte that the ADPCM input carried in the same slot. PCM output 2 stays high impedance.
- R4: Octet mode, select=1. The ADPCM output drives the byte that PCM input 2 carried in the same slot. PCM output 2 drives the byte that the ADPCM input carried in the same slot. PCM output 1 stays high impedance.
- R5: Codeword mode. The ADPCM output is active only in the slot picked by select (strobe 1 when select=0, strobe 2 when select=1). In that slot it sends four 2-bit words, first to last:
  - the first two serial bits of PCM input 1, slot 1;
  - the first two serial bits of PCM input 1, slot 2;
  - the first two serial bits of PCM input 2, slot 1;
  - the first two serial bits of PCM input 2, slot 2.

  The other six input bits of each slot are ignored.
- R6: Codeword mode. The ADPCM input byte taken in the selected slot is split into four 2-bit words, in serial order. Word 0 goes to PCM output 1, slot 1. Word 1 goes to PCM output 1, slot 2. Word 2 goes to PCM output 2, slot 1. Word 3 goes to PCM output 2, slot 2. Each word takes the first two serial positions of its slot, and the remaining six positions are driven 0. The PCM outputs are active in both slots.
- R7: Serial data travels most significant bit first. Inputs are sampled at falling edges of `bclk`, and output bits advance only at rising edges of `bclk`.
- R8: Every output is high impedance whenever its strobe window is not active.
- R9: When `en_pcm_out` is low, both PCM outputs are high impedance. When `en_adpcm_out` is low, the ADPCM output is high impedance. Capture continues in both cases, so data taken while an output was disabled still appears two frames later.
- R10: Each strobe lasts eight bit periods. At most one strobe is high at a time. The frame advances when the second strobe window ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Serial bit clock |
| strb1 | input | 1 | Strobe for timeslot 1, high for eight bit periods |
| strb2 | input | 1 | Strobe for timeslot 2, high for eight bit periods |
| pcm_in1 | input | 1 | Serial PCM input line 1 |
| pcm_in2 | input | 1 | Serial PCM input line 2 |
| adpcm_in | input | 1 | Serial ADPCM input line |
| mode_cw | input | 1 | 0 = octet bypass, 1 = 2-bit codeword bypass |
| sel | input | 1 | Channel-pair or timeslot select |
| en_pcm_out | input | 1 | Enable for both PCM outputs |
| en_adpcm_out | input | 1 | Enable for the ADPCM output |
| pcm_out1 | output | 1 | Serial PCM output line 1, tri-state |
| pcm_out2 | output | 1 | Serial PCM output line 2, tri-state |
| adpcm_out | output | 1 | Serial ADPCM output line, tri-state |

## Verification
The bench drives a byte pattern numbered by frame, stream and slot, under every combination of mode and select. For every bit period of every frame it computes the expected level of all three outputs, including high impedance. A pointer that skipped or repeated a bank would show the data of frame N-1 or N-3, and a design that read its storage before the slot-2 capture of the current frame could overwrite it would show corrupted codewords when select=1.

The adjacent slot-1/slot-2 windows test the wrap of the bit counter. If the counter wrapped wrongly, the second slot would be shifted by one bit. The don't-care bits of codeword mode carry changing junk, so a packer that took the wrong bits would be caught. Frames in which an output is disabled are followed by enabled frames, which catches a design that stops capturing while its output is disabled.

// File: rtl/fdb_pkg.sv
package fdb_pkg;
    localparam int SLOT_BITS   = 8;
    localparam int NUM_SLOTS   = 2;
    localparam int NUM_STREAMS = 3;
    localparam int WORD_BITS   = 2;
    localparam int STREAM_PCM1 = 0;
    localparam int STREAM_PCM2 = 1;
    localparam int STREAM_ADP  = 2;
    localparam int IDX_W       = $clog2(SLOT_BITS);
    localparam int SLOT_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    typedef logic [SLOT_BITS-1:0] slot_byte_t;
    typedef slot_byte_t [NUM_SLOTS-1:0] stream_bytes_t;
    typedef stream_bytes_t [NUM_STREAMS-1:0] frame_bytes_t;

    typedef enum logic {
        BYP_OCTET    = 1'b0,
        BYP_CODEWORD = 1'b1
    } byp_mode_e;
endpackage

// File: rtl/fdb_bclk_edges.sv
module fdb_bclk_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic sync;
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d.sync = bclk;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.sync & ~st_q.prev;
    assign fall = ~st_q.sync & st_q.prev;
endmodule

// File: rtl/fdb_capture.sv
module fdb_capture
    import fdb_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fall,
    input  logic [NUM_SLOTS-1:0]     strb,
    input  logic [NUM_STREAMS-1:0]   din,
    output logic                     wr_en,
    output logic [SLOT_W-1:0]        wr_slot,
    output slot_byte_t [NUM_STREAMS-1:0] wr_data,
    output logic                     frame_done,
    output logic                     strb_seen
);
    typedef struct packed {
        logic [IDX_W-1:0]               cnt;
        slot_byte_t [NUM_STREAMS-1:0]   shreg;
        logic                           wr_en;
        logic [SLOT_W-1:0]              wr_slot;
        logic                           frame_done;
        logic                           seen;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic [SLOT_W-1:0] slot_enc;

    always_comb begin
        slot_enc = '0;
        for (int t = 0; t < NUM_SLOTS; t++) begin
            if (strb[t]) slot_enc = SLOT_W'(t);
        end
    end

    always_comb begin
        st_d            = st_q;
        st_d.wr_en      = 1'b0;
        st_d.frame_done = 1'b0;
        if (fall) begin
            st_d.seen = |strb;
            if (|strb) begin
                for (int s = 0; s < NUM_STREAMS; s++) begin
                    st_d.shreg[s] = {st_q.shreg[s][SLOT_BITS-2:0], din[s]};
                end
                if (st_q.cnt == IDX_W'(SLOT_BITS-1)) begin
                    st_d.cnt        = '0;
                    st_d.wr_en      = 1'b1;
                    st_d.wr_slot    = slot_enc;
                    st_d.frame_done = strb[NUM_SLOTS-1];
                end else begin
                    st_d.cnt = st_q.cnt + IDX_W'(1);
                end
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en      = st_q.wr_en;
    assign wr_slot    = st_q.wr_slot;
    assign wr_data    = st_q.shreg;
    assign frame_done = st_q.frame_done;
    assign strb_seen  = st_q.seen;

    assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb));

    assert_write_follows_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(fall));
endmodule

// File: rtl/fdb_frame_store.sv
module fdb_frame_store
    import fdb_pkg::*;
#(
    parameter int DELAY_FRAMES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rise,
    input  logic                         wr_en,
    input  logic [SLOT_W-1:0]            wr_slot,
    input  slot_byte_t [NUM_STREAMS-1:0] wr_data,
    input  logic                         frame_done,
    output frame_bytes_t                 rd_bytes
);
    localparam int NUM_BANKS = DELAY_FRAMES + 1;
    localparam int BANK_W    = $clog2(NUM_BANKS);

    typedef struct packed {
        frame_bytes_t [NUM_BANKS-1:0] bank;
        logic [BANK_W-1:0]            wp;
        logic                         pending;
    } store_state_t;

    store_state_t st_d, st_q;
    logic [BANK_W-1:0] rp;

    always_comb begin
        rp = (st_q.wp == BANK_W'(NUM_BANKS-1)) ? '0 : st_q.wp + BANK_W'(1);
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int s = 0; s < NUM_STREAMS; s++) begin
                st_d.bank[st_q.wp][s][wr_slot] = wr_data[s];
            end
            if (frame_done) st_d.pending = 1'b1;
        end
        if (st_q.pending && rise) begin
            st_d.pending = 1'b0;
            st_d.wp      = rp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_bytes = st_q.bank[rp];

    assert_bank_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wp <= BANK_W'(NUM_BANKS-1));

    assert_ptr_steps_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wp != $past(st_q.wp)) |-> $past(rise));

    assert_frame_end_is_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> wr_en);
endmodule

// File: rtl/fdb_out_router.sv
module fdb_out_router
    import fdb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rise,
    input  logic                   strb_seen,
    input  logic [NUM_SLOTS-1:0]   strb,
    input  byp_mode_e              mode,
    input  logic                   sel,
    input  logic                   en_pcm,
    input  logic                   en_adp,
    input  frame_bytes_t           rd_bytes,
    output logic [NUM_STREAMS-1:0] out_bit,
    output logic [NUM_STREAMS-1:0] out_oe
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } rtr_state_t;

    rtr_state_t st_d, st_q;
    logic [SLOT_W-1:0]            cur_slot;
    logic                         active;
    slot_byte_t                   packed_cw;
    slot_byte_t                   adp_src;
    slot_byte_t [NUM_STREAMS-1:0] obyte;

    always_comb begin
        st_d = st_q;
        if (rise) begin
            if (strb_seen && st_q.idx != IDX_W'(SLOT_BITS-1)) st_d.idx = st_q.idx + IDX_W'(1);
            else                                              st_d.idx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        active   = |strb;
        cur_slot = '0;
        for (int t = 0; t < NUM_SLOTS; t++) begin
            if (strb[t]) cur_slot = SLOT_W'(t);
        end

        packed_cw = '0;
        for (int p = 0; p < NUM_STREAMS-1; p++) begin
            for (int t = 0; t < NUM_SLOTS; t++) begin
                packed_cw[SLOT_BITS-1-(p*NUM_SLOTS+t)*WORD_BITS -: WORD_BITS] =
                    rd_bytes[p][t][SLOT_BITS-1 -: WORD_BITS];
            end
        end
        adp_src = rd_bytes[STREAM_ADP][sel];

        obyte  = '0;
        out_oe = '0;
        if (mode == BYP_OCTET) begin
            obyte[STREAM_ADP]  = rd_bytes[sel ? STREAM_PCM2 : STREAM_PCM1][cur_slot];
            out_oe[STREAM_ADP] = active & en_adp;
            for (int p = 0; p < NUM_STREAMS-1; p++) begin
                obyte[p]  = rd_bytes[STREAM_ADP][cur_slot];
                out_oe[p] = active & en_pcm & (int'(sel) == p);
            end
        end else begin
            obyte[STREAM_ADP]  = packed_cw;
            out_oe[STREAM_ADP] = strb[sel] & en_adp;
            for (int p = 0; p < NUM_STREAMS-1; p++) begin
                obyte[p][SLOT_BITS-1 -: WORD_BITS] =
                    adp_src[SLOT_BITS-1-(p*NUM_SLOTS+int'(cur_slot))*WORD_BITS -: WORD_BITS];
                out_oe[p] = active & en_pcm;
            end
        end

        for (int s = 0; s < NUM_STREAMS; s++) begin
            out_bit[s] = obyte[s][SLOT_BITS-1-int'(st_q.idx)];
        end
    end

    assert_bit_moves_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(st_q.idx));

    assert_oe_inside_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_oe) |-> (|strb));

    assert_single_pcm_in_octet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == BYP_OCTET) |-> !(out_oe[STREAM_PCM1] && out_oe[STREAM_PCM2]));

    assert_cw_pad_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == BYP_CODEWORD && out_oe[STREAM_PCM1] && st_q.idx >= IDX_W'(WORD_BITS))
        |-> !out_bit[STREAM_PCM1]);
endmodule

// File: rtl/frame_delay_bypass.sv
module frame_delay_bypass
    import fdb_pkg::*;
#(
    parameter int DELAY_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic strb1,
    input  logic strb2,
    input  logic pcm_in1,
    input  logic pcm_in2,
    input  logic adpcm_in,
    input  logic mode_cw,
    input  logic sel,
    input  logic en_pcm_out,
    input  logic en_adpcm_out,
    output logic pcm_out1,
    output logic pcm_out2,
    output logic adpcm_out
);
    logic                         rise, fall;
    logic [NUM_SLOTS-1:0]         strb;
    logic [NUM_STREAMS-1:0]       din;
    logic                         wr_en, frame_done, strb_seen;
    logic [SLOT_W-1:0]            wr_slot;
    slot_byte_t [NUM_STREAMS-1:0] wr_data;
    frame_bytes_t                 rd_bytes;
    logic [NUM_STREAMS-1:0]       out_bit, out_oe;
    byp_mode_e                    mode;

    assign strb = {strb2, strb1};
    assign din  = {adpcm_in, pcm_in2, pcm_in1};
    assign mode = byp_mode_e'(mode_cw);

    fdb_bclk_edges u_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .bclk (bclk),
        .rise (rise),
        .fall (fall)
    );

    fdb_capture u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall      (fall),
        .strb      (strb),
        .din       (din),
        .wr_en     (wr_en),
        .wr_slot   (wr_slot),
        .wr_data   (wr_data),
        .frame_done(frame_done),
        .strb_seen (strb_seen)
    );

    fdb_frame_store #(.DELAY_FRAMES(DELAY_FRAMES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .wr_en     (wr_en),
        .wr_slot   (wr_slot),
        .wr_data   (wr_data),
        .frame_done(frame_done),
        .rd_bytes  (rd_bytes)
    );

    fdb_out_router u_router (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .strb_seen(strb_seen),
        .strb     (strb),
        .mode     (mode),
        .sel      (sel),
        .en_pcm   (en_pcm_out),
        .en_adp   (en_adpcm_out),
        .rd_bytes (rd_bytes),
        .out_bit  (out_bit),
        .out_oe   (out_oe)
    );

    assign pcm_out1  = out_oe[STREAM_PCM1] ? out_bit[STREAM_PCM1] : 1'bz;
    assign pcm_out2  = out_oe[STREAM_PCM2] ? out_bit[STREAM_PCM2] : 1'bz;
    assign adpcm_out = out_oe[STREAM_ADP]  ? out_bit[STREAM_ADP]  : 1'bz;
endmodule

// File: tb/frame_delay_bypass_bench.sv
module frame_delay_bypass_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, bclk, strb1, strb2, pcm_in1, pcm_in2, adpcm_in;
    logic mode_cw, sel, en_pcm_out, en_adpcm_out;
    wire  pcm_out1, pcm_out2, adpcm_out;

    int checks   = 0;
    int failures = 0;

    frame_delay_bypass u_frame_delay_bypass (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .strb1(strb1), .strb2(strb2),
        .pcm_in1(pcm_in1), .pcm_in2(pcm_in2), .adpcm_in(adpcm_in),
        .mode_cw(mode_cw), .sel(sel), .en_pcm_out(en_pcm_out), .en_adpcm_out(en_adpcm_out),
        .pcm_out1(pcm_out1), .pcm_out2(pcm_out2), .adpcm_out(adpcm_out)
    );

    function automatic logic [7:0] pat(int f, int s, int t);
        return 8'((f * 37 + s * 11 + t * 5 + 3) & 255);
    endfunction

    function automatic logic [7:0] src(int g, int s, int t);
        if (g < 0) return 8'h00;
        return pat(g, s, t);
    endfunction

    function automatic logic exp_bit(int f, int k, int o, logic m, logic sl, logic ep, logic ea);
        int slot;
        int g;
        int j;
        logic [7:0] b, a, w0, w1, w2, w3;
        slot = (k < 8) ? 0 : ((k < 16) ? 1 : -1);
        g = f - 2;
        if (slot < 0) return 1'bz;
        if (!m) begin
            if (o == 2) begin
                if (!ea) return 1'bz;
                b = src(g, sl ? 1 : 0, slot);
            end else begin
                if (!ep || o != int'(sl)) return 1'bz;
                b = src(g, 2, slot);
            end
        end else begin
            if (o == 2) begin
                if (!ea || slot != int'(sl)) return 1'bz;
                w0 = src(g, 0, 0); w1 = src(g, 0, 1); w2 = src(g, 1, 0); w3 = src(g, 1, 1);
                b = {w0[7:6], w1[7:6], w2[7:6], w3[7:6]};
            end else begin
                if (!ep) return 1'bz;
                a = src(g, 2, int'(sl));
                j = o * 2 + slot;
                b = {a[7 - 2 * j -: 2], 6'b0};
            end
        end
        return b[7 - (k % 8)];
    endfunction

    function automatic string tag(int f, int k, int o, logic m, logic sl, logic ep, logic ea);
        if (k >= 16) return "R8";
        if ((o != 2 && !ep) || (o == 2 && !ea)) return "R9";
        if (f < 2) return "R1 R2";
        if (!m) return sl ? "R4 R2 R7" : "R3 R2 R7";
        return (o == 2) ? "R5 R2 R10" : "R6 R2";
    endfunction

    task automatic check(string t, logic got, logic exp, int f, int k, int o);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s frame=%0d bit=%0d out=%0d actual=%b expected=%b", t, f, k, o, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bclk = 1'b0; strb1 = 1'b0; strb2 = 1'b0;
        pcm_in1 = 1'b0; pcm_in2 = 1'b0; adpcm_in = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 R8", pcm_out1, 1'bz, -1, 0, 0);
        check("R1 R8", pcm_out2, 1'bz, -1, 0, 1);
        check("R1 R8", adpcm_out, 1'bz, -1, 0, 2);
    endtask

    task automatic run_frame(int f, logic ep, logic ea);
        for (int k = 0; k < 24; k++) begin
            int slot;
            logic [7:0] b0, b1, b2;
            logic got;
            slot = (k < 8) ? 0 : ((k < 16) ? 1 : -1);
            @(negedge clk);
            bclk = 1'b1;
            en_pcm_out = ep;
            en_adpcm_out = ea;
            strb1 = (slot == 0);
            strb2 = (slot == 1);
            if (slot >= 0) begin
                b0 = pat(f, 0, slot); b1 = pat(f, 1, slot); b2 = pat(f, 2, slot);
                pcm_in1 = b0[7 - (k % 8)];
                pcm_in2 = b1[7 - (k % 8)];
                adpcm_in = b2[7 - (k % 8)];
            end else begin
                pcm_in1 = 1'((f + k) & 1);
                pcm_in2 = 1'((f + k + 1) & 1);
                adpcm_in = 1'(k & 1);
            end
            repeat (3) @(negedge clk);
            for (int o = 0; o < 3; o++) begin
                got = (o == 0) ? pcm_out1 : ((o == 1) ? pcm_out2 : adpcm_out);
                check(tag(f, k, o, mode_cw, sel, ep, ea), got,
                      exp_bit(f, k, o, mode_cw, sel, ep, ea), f, k, o);
            end
            bclk = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        en_pcm_out = 1'b1; en_adpcm_out = 1'b1; mode_cw = 1'b0; sel = 1'b0;
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 2; s++) begin
                mode_cw = 1'(m);
                sel = 1'(s);
                do_reset();
                for (int f = 0; f < 6; f++) run_frame(f, 1'b1, 1'b1);
            end
        end
        // R9: outputs disabled for some frames, capture keeps running
        mode_cw = 1'b0; sel = 1'b0;
        do_reset();
        for (int f = 0; f < 6; f++) run_frame(f, (f != 2 && f != 3), (f != 3));
        mode_cw = 1'b1; sel = 1'b1;
        do_reset();
        for (int f = 0; f < 5; f++) run_frame(f, (f != 2), (f != 2));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule